// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block sits between a memory controller's command path and the column decoder of a DRAM-style array. It holds a small mode word, written through a load strobe. For each accepted READ or WRITE command, it steps out the column address of every beat in the burst, one beat per clock. The mode word picks a burst length of 2, 4, 8 or 16 and a sequential or interleaved beat order. In both orders the address wraps inside an aligned block whose size equals the burst length.

The mode word also holds a read latency of 2 or 3 clocks. For read bursts, the block delays the beat-valid indication by that latency minus one clock and drives it out as a read-data strobe. The finer output-access delay of the array is modelled outside the block.

Top module: `burst_col_seq`

## Requirements
- R1: On `mr_load`, `mr_addr[2:0]` selects the burst length (001=2, 010=4, 011=8, 100=16), `mr_addr[3]` selects the order (0 sequential, 1 interleaved), and `mr_addr[6:4]` selects the read latency (010=2, 011=3). The new mode applies to commands accepted after the load edge.
- R2: After reset the mode is burst length 2, sequential order, read latency 2. All outputs are low.
- R3: During a burst, the column bits above log2(BL) equal those of the starting column on every beat.
- R4: In sequential order, the low log2(BL) bits of beat k equal (start + k) mod BL.
- R5: In interleaved order, the low log2(BL) bits of beat k equal start XOR k.
- R6: A command registered at edge n drives beat k during the cycle after edge n+k. `beat_valid` is high for exactly BL cycles. `beat_last` is high only on beat BL-1.
- R7: For a read burst, `rd_strobe` is high during the cycle after edge n+k+CL-1 for each beat k. It stays low for write bursts.
- R8: A mode load with a burst-length code or latency code outside the listed values leaves the whole mode unchanged. It pulses `mode_err` for one cycle.
- R9: A command presented while a non-last beat is on the outputs is ignored. The burst in progress continues unchanged, and `cmd_err` pulses for one cycle.
- R10: A command presented while the last beat is on the outputs is accepted. Its first beat follows directly, with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mr_load | input | 1 | Mode word load strobe |
| mr_addr | input | 8 | Mode word (length, order, latency fields) |
| cmd_valid | input | 1 | Command strobe |
| cmd_is_read | input | 1 | 1 = READ, 0 = WRITE |
| cmd_col | input | COL_W | Starting column |
| beat_col | output | COL_W | Column address of the current beat |
| beat_valid | output | 1 | A beat is on `beat_col` |
| beat_last | output | 1 | Current beat is the final one |
| rd_strobe | output | 1 | Read data due, delayed by latency minus one |
| mode_err | output | 1 | Reserved code in the last mode load |
| cmd_err | output | 1 | Last command was dropped because a burst was active |

## Verification
The assertions check the following on every clock: the block bits stay fixed and the sequential step holds within a burst, `beat_last` never appears without `beat_valid`, every strobe follows a beat by one or two clocks, and each error pulse has its cause in the cycle before. Whether the interleaved order, the full beat count, the exact strobe cycle for a given latency and the kept mode after a reserved load are right can only be seen in the bench's scenarios. Those scenarios compare each beat against a reference built from modulo addition and XOR.

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mr_load,
  input  logic [7:0]       mr_addr,
  input  logic             cmd_valid,
  input  logic             cmd_is_read,
  input  logic [COL_W-1:0] cmd_col,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_valid,
  output logic             beat_last,
  output logic             rd_strobe,
  output logic             mode_err,
  output logic             cmd_err
);
  localparam int LW = 4;

  logic [1:0] m_len;
  logic       m_ilv;
  logic       m_cl3;

  logic          act_q;
  logic [LW-1:0] k_q;
  logic [COL_W-1:0] st_q;
  logic [1:0]    len_q;
  logic          ilv_q;
  logic          cl3_q;
  logic          rd_q;
  logic          s1_v, s1_c, s2_v, s2_c;

  logic [2:0] len_code;
  logic [2:0] cl_code;
  logic       len_ok, cl_ok;
  assign len_code = mr_addr[2:0];
  assign cl_code  = mr_addr[6:4];
  assign len_ok   = (len_code >= 3'd1) && (len_code <= 3'd4);
  assign cl_ok    = (cl_code == 3'd2) || (cl_code == 3'd3);

  function automatic logic [LW-1:0] mask_of(input logic [1:0] sel);
    case (sel)
      2'd0:    mask_of = 4'h1;
      2'd1:    mask_of = 4'h3;
      2'd2:    mask_of = 4'h7;
      default: mask_of = 4'hF;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_len    <= 2'd0;
      m_ilv    <= 1'b0;
      m_cl3    <= 1'b0;
      mode_err <= 1'b0;
    end else begin
      mode_err <= mr_load && !(len_ok && cl_ok);
      if (mr_load && len_ok && cl_ok) begin
        m_len <= 2'(len_code - 3'd1);
        m_ilv <= mr_addr[3];
        m_cl3 <= (cl_code == 3'd3);
      end
    end
  end

  logic [LW-1:0] bmask, low;
  logic busy, accept;
  assign bmask     = mask_of(len_q);
  assign low       = ilv_q ? (st_q[LW-1:0] ^ k_q) : (st_q[LW-1:0] + k_q);
  assign beat_valid = act_q;
  assign beat_last  = act_q && (k_q == bmask);
  assign beat_col   = {st_q[COL_W-1:LW], (st_q[LW-1:0] & ~bmask) | (low & bmask)};
  assign busy       = act_q && !beat_last;
  assign accept     = cmd_valid && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      k_q     <= '0;
      st_q    <= '0;
      len_q   <= 2'd0;
      ilv_q   <= 1'b0;
      cl3_q   <= 1'b0;
      rd_q    <= 1'b0;
      cmd_err <= 1'b0;
    end else begin
      cmd_err <= cmd_valid && busy;
      if (accept) begin
        act_q <= 1'b1;
        k_q   <= '0;
        st_q  <= cmd_col;
        len_q <= m_len;
        ilv_q <= m_ilv;
        cl3_q <= m_cl3;
        rd_q  <= cmd_is_read;
      end else if (act_q) begin
        if (beat_last) act_q <= 1'b0;
        else           k_q   <= k_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_c <= 1'b0;
      s2_v <= 1'b0; s2_c <= 1'b0;
    end else begin
      s1_v <= act_q && rd_q;
      s1_c <= cl3_q;
      s2_v <= s1_v;
      s2_c <= s1_c;
    end
  end

  assign rd_strobe = (s1_v && !s1_c) || (s2_v && s2_c);

  a_r3_block_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last) |=> $stable(beat_col | COL_W'(bmask)));

  a_r4_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last && !ilv_q) |=>
      ((beat_col & COL_W'(bmask)) == (($past(beat_col) + 1'b1) & COL_W'(bmask))));

  a_r6_last_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid);

  a_r7_strobe_follows_beat: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |-> ($past(beat_valid) || $past(beat_valid, 2)));

  a_r8_mode_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> $past(mr_load));

  a_r9_cmd_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(cmd_valid && beat_valid && !beat_last));
endmodule

// File: tb/test_burst_col_seq.sv
`timescale 1ns/1ps
module test_burst_col_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mr_load = 1'b0;
  logic [7:0] mr_addr = '0;
  logic       cmd_valid = 1'b0;
  logic       cmd_is_read = 1'b0;
  logic [9:0] cmd_col = '0;
  logic [9:0] beat_col;
  logic       beat_valid, beat_last, rd_strobe, mode_err, cmd_err;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  burst_col_seq #(.COL_W(10)) i_burst_col_seq (
    .clk(clk), .rst_n(rst_n), .mr_load(mr_load), .mr_addr(mr_addr),
    .cmd_valid(cmd_valid), .cmd_is_read(cmd_is_read), .cmd_col(cmd_col),
    .beat_col(beat_col), .beat_valid(beat_valid), .beat_last(beat_last),
    .rd_strobe(rd_strobe), .mode_err(mode_err), .cmd_err(cmd_err));

  // {len_code[2:0], interleaved, cl_code[2:0], is_read, start[9:0]}
  localparam logic [17:0] VEC [16] = '{
    {3'd1, 1'b0, 3'd2, 1'b1, 10'h001},
    {3'd1, 1'b1, 3'd3, 1'b1, 10'h2A0},
    {3'd2, 1'b0, 3'd2, 1'b1, 10'h3A6},
    {3'd2, 1'b1, 3'd3, 1'b0, 10'h0C7},
    {3'd3, 1'b0, 3'd2, 1'b1, 10'h105},
    {3'd3, 1'b1, 3'd3, 1'b1, 10'h1F3},
    {3'd3, 1'b0, 3'd3, 1'b0, 10'h3FF},
    {3'd3, 1'b1, 3'd2, 1'b1, 10'h088},
    {3'd4, 1'b0, 3'd2, 1'b1, 10'h04A},
    {3'd4, 1'b1, 3'd3, 1'b1, 10'h0EA},
    {3'd4, 1'b1, 3'd2, 1'b0, 10'h37D},
    {3'd4, 1'b0, 3'd3, 1'b1, 10'h210},
    {3'd2, 1'b1, 3'd2, 1'b1, 10'h155},
    {3'd4, 1'b1, 3'd3, 1'b1, 10'h00F},
    {3'd1, 1'b1, 3'd2, 1'b0, 10'h3FE},
    {3'd4, 1'b0, 3'd2, 1'b0, 10'h3F1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] ref_col(input logic [9:0] st, input int bl, input bit ilv, input int k);
    logic [9:0] m, lo;
    m  = 10'(bl - 1);
    lo = ilv ? (st ^ 10'(k)) : 10'(st + 10'(k));
    return (st & ~m) | (lo & m);
  endfunction

  task automatic load_mode(input logic [7:0] w, input bit exp_err);
    mr_load = 1'b1; mr_addr = w;
    @(negedge clk);
    mr_load = 1'b0;
    chk(mode_err == exp_err, exp_err ? "R8 mode_err pulse" : "R1 mode_err low", mode_err, exp_err);
  endtask

  task automatic burst(input int bl, input bit ilv, input int cl, input bit rd, input logic [9:0] st);
    cmd_valid = 1'b1; cmd_is_read = rd; cmd_col = st;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int j = 0; j < bl + 3; j++) begin
      bit es;
      if (j < bl) begin
        logic [9:0] e;
        e = ref_col(st, bl, ilv, j);
        chk(beat_valid, "R6 beat_valid", beat_valid, 1);
        chk(beat_col == e, ilv ? "R5 interleaved col" : "R4 sequential col", beat_col, e);
        chk(beat_col[9:4] == st[9:4], "R3 block bits", beat_col[9:4], st[9:4]);
        chk(beat_last == (j == bl - 1), "R6 beat_last", beat_last, (j == bl - 1));
      end else begin
        chk(!beat_valid, "R6 beat_valid after burst", beat_valid, 0);
      end
      es = rd && (j >= cl - 1) && (j - (cl - 1) < bl);
      chk(rd_strobe == es, "R7 rd_strobe", rd_strobe, es);
      @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 200000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!beat_valid && !beat_last && !rd_strobe && !mode_err && !cmd_err, "R2 outputs in reset",
        {beat_valid, beat_last, rd_strobe, mode_err, cmd_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!beat_valid && !rd_strobe, "R2 idle after reset", {beat_valid, rd_strobe}, 0);
    // R2: default mode BL=2 sequential CL=2
    burst(2, 1'b0, 2, 1'b1, 10'h007);

    foreach (VEC[i]) begin
      logic [17:0] v;
      v = VEC[i];
      load_mode({1'b0, v[13:11], v[14], v[17:15]}, 1'b0);
      burst(1 << v[17:15], v[14], int'(v[13:11]), v[10], v[9:0]);
    end

    // R4 R5: every start for BL=16 in both orders
    for (int t = 0; t < 2; t++) begin
      load_mode({1'b0, 3'd2, t[0], 3'd4}, 1'b0);
      for (int s = 0; s < 16; s++) burst(16, t[0], 2, 1'b0, 10'(10'h150 + s));
    end

    // R8: reserved length code keeps BL=4 interleaved CL=3
    load_mode({1'b0, 3'd3, 1'b1, 3'd2}, 1'b0);
    load_mode({1'b0, 3'd2, 1'b0, 3'd5}, 1'b1);
    @(negedge clk);
    chk(!mode_err, "R8 mode_err one cycle", mode_err, 0);
    burst(4, 1'b1, 3, 1'b1, 10'h0B1);
    // R8: reserved latency code
    load_mode({1'b0, 3'd1, 1'b0, 3'd3}, 1'b1);
    burst(4, 1'b1, 3, 1'b1, 10'h0B2);

    // R9: command during a burst is ignored
    load_mode({1'b0, 3'd2, 1'b0, 3'd3}, 1'b0);
    cmd_valid = 1'b1; cmd_is_read = 1'b0; cmd_col = 10'h010;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int j = 0; j < 10; j++) begin
      if (j == 3) chk(cmd_err, "R9 cmd_err pulse", cmd_err, 1);
      else        chk(!cmd_err, "R9 cmd_err quiet", cmd_err, 0);
      if (j < 8) chk(beat_valid && beat_col == 10'(10'h010 + j), "R9 burst unchanged", beat_col, 10'h010 + j);
      else       chk(!beat_valid, "R9 no second burst", beat_valid, 0);
      if (j == 2) begin cmd_valid = 1'b1; cmd_col = 10'h3FF; end
      @(negedge clk);
      cmd_valid = 1'b0;
    end

    // R10: back-to-back on the last beat
    load_mode({1'b0, 3'd2, 1'b1, 3'd2}, 1'b0);
    cmd_valid = 1'b1; cmd_is_read = 1'b0; cmd_col = 10'h021;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int j = 0; j < 9; j++) begin
      logic [9:0] e;
      e = (j < 4) ? ref_col(10'h021, 4, 1'b1, j) : ref_col(10'h046, 4, 1'b1, j - 4);
      if (j < 8) chk(beat_valid && beat_col == e, "R10 back-to-back col", beat_col, e);
      else       chk(!beat_valid, "R10 idle after", beat_valid, 0);
      chk(!cmd_err, "R10 no cmd_err", cmd_err, 0);
      if (j == 3) begin
        chk(beat_last, "R10 last before accept", beat_last, 1);
        cmd_valid = 1'b1; cmd_col = 10'h046;
      end
      @(negedge clk);
      cmd_valid = 1'b0;
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule